// File: doc/BRIEF.md
# GF(2^m) Power-Sum Pipeline

This block evaluates A·B² + C over the binary extension field GF(2^m). Each operand is an m-bit field element in polynomial basis, where bit i holds the coefficient of x^i. The reducing polynomial and the field size are parameters. The block is intended as a building block for exponentiation, inversion and division chains. Those algorithms repeatedly need a square, a multiply and an accumulate, and this block fuses the three into one stream operation.

The datapath is a linear chain of m identical cells, each followed by a register. B is first squared by a fixed XOR network and reduced by the field polynomial. The chain then folds in one bit of A per cell, most significant bit first. Each fold is an AND feeding an XOR, so the logic between registers stays at roughly two gate levels. C is added at the final cell. A, C and the square of B travel down the chain beside the running partial product.

All operand bits enter together and all result bits leave together. A new operand set may be offered on every clock. The interface is a plain valid flag in each direction, with no backpressure. A control part shifts the valid flags and turns them into per-stage load strobes. Only the valid flags are reset.

Top module: `gf_psum`

## Requirements
- R1: When outVld is high, resOut equals A·B² + C reduced modulo POLY. Here A, B and C are the aIn, bIn and cIn values that were sampled with inVld high M rising edges earlier. Bit i of every operand and of the result is the coefficient of x^i.
- R2: An operand set is accepted at every rising edge where inVld is high. Valid inputs on consecutive edges produce valid results on consecutive cycles, in the same order.
- R3: Count the edge that samples an operand set as the first rising edge. outVld is high just after the M-th rising edge. An edge that samples inVld low yields outVld low at the same distance.
- R4: While rstN is low, outVld is low. After rstN is released, outVld stays low until an operand set accepted after the release has travelled the full M edges.
- R5: With A = 1 and C = 0, the result is B² reduced modulo POLY.
- R6: With A = 0 or B = 0, the result equals C.
- R7: The default field is M = 4 with POLY = 5'b10011, which is x^4 + x + 1 (bit i is the coefficient of x^i). In this field x^4 reduces to x + 1, so B = 4'b0100 gives B² = 4'b0011.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous active-low reset of the valid flags |
| inVld | input | 1 | Operand set on aIn, bIn and cIn is valid this cycle |
| aIn | input | M | Multiplier A |
| bIn | input | M | Element B, which is squared |
| cIn | input | M | Addend C |
| outVld | output | 1 | resOut holds a valid result |
| resOut | output | M | A·B² + C |

## Verification
The checker assumes that inVld is never unknown outside reset. It also assumes that aIn, bIn and cIn carry defined values whenever inVld is high, because its shadow model of the expected result is built from those values. The checker also takes POLY to be a degree-M polynomial with a nonzero constant term. The bench keeps inside these assumptions: it drives every input at falling edges, holds defined zero operands during idle cycles, and uses only the default irreducible polynomial.

// File: rtl/gf_psum_pkg.sv
package gf_psum_pkg;

  // Upper bound on pipeline depth carried by the strobe bundle.
  localparam int MAX_STAGES = 16;

  // Strobes sent from the control part to the datapath.
  typedef struct packed {
    logic [MAX_STAGES-1:0] loadEn;  // stage k register captures this cycle
  } psum_strobe_t;

endpackage

// File: rtl/gf_psum_cell.sv
// One systolic step: shift the running product by x, reduce, and
// conditionally accumulate the squared operand (AND feeding XOR).
module gf_psum_cell #(
  parameter int         M    = 4,
  parameter logic [M:0] POLY = 5'b10011
) (
  input  logic [M-1:0] pIn,
  input  logic [M-1:0] sIn,
  input  logic         aBit,
  output logic [M-1:0] pOut
);

  logic [M-1:0] shifted;

  assign shifted = {pIn[M-2:0], 1'b0} ^ ({M{pIn[M-1]}} & POLY[M-1:0]);
  assign pOut    = shifted ^ ({M{aBit}} & sIn);

endmodule

// File: rtl/gf_psum_ctrl.sv
// Valid-flag shift chain; produces per-stage load strobes.
module gf_psum_ctrl
  import gf_psum_pkg::*;
#(
  parameter int M = 4
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         inVld,
  output psum_strobe_t strb,
  output logic         outVld
);

  logic [M-1:0] vldPipe;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      vldPipe <= '0;
    end else begin
      vldPipe <= {vldPipe[M-2:0], inVld};
    end
  end

  always_comb begin
    strb           = '0;
    strb.loadEn[0] = inVld;
    for (int k = 1; k < M; k++) begin
      strb.loadEn[k] = vldPipe[k-1];
    end
  end

  assign outVld = vldPipe[M-1];

endmodule

// File: rtl/gf_psum_datapath.sv
// Squaring network followed by M registered cells. Data registers
// load only when their stage strobe is set and carry no reset.
module gf_psum_datapath
  import gf_psum_pkg::*;
#(
  parameter int         M    = 4,
  parameter logic [M:0] POLY = 5'b10011
) (
  input  logic         clk,
  input  psum_strobe_t strb,
  input  logic [M-1:0] aIn,
  input  logic [M-1:0] bIn,
  input  logic [M-1:0] cIn,
  output logic [M-1:0] resOut
);

  localparam int LAST = M - 1;

  function automatic logic [M-1:0] mulByX(input logic [M-1:0] v);
    return {v[M-2:0], 1'b0} ^ ({M{v[M-1]}} & POLY[M-1:0]);
  endfunction

  // Squaring is linear over GF(2): bit i of B contributes x^(2i) mod POLY.
  function automatic logic [M-1:0] squareOf(input logic [M-1:0] b);
    logic [M-1:0] acc;
    logic [M-1:0] pw;
    acc = '0;
    pw  = {{(M-1){1'b0}}, 1'b1};
    for (int i = 0; i < M; i++) begin
      if (b[i]) acc = acc ^ pw;
      pw = mulByX(mulByX(pw));
    end
    return acc;
  endfunction

  logic [M-1:0] sqIn;
  logic [M-1:0] pPipe [M];
  logic [M-1:0] aPipe [LAST];
  logic [M-1:0] cPipe [LAST];
  logic [M-1:0] sPipe [LAST];

  assign sqIn = squareOf(bIn);

  for (genvar k = 0; k < M; k++) begin : g_stage
    logic [M-1:0] pPrev;
    logic [M-1:0] sPrev;
    logic [M-1:0] aPrev;
    logic [M-1:0] cPrev;
    logic [M-1:0] pNext;

    if (k == 0) begin : g_head
      assign pPrev = '0;
      assign sPrev = sqIn;
      assign aPrev = aIn;
      assign cPrev = cIn;
    end else begin : g_body
      assign pPrev = pPipe[k-1];
      assign sPrev = sPipe[k-1];
      assign aPrev = aPipe[k-1];
      assign cPrev = cPipe[k-1];
    end

    gf_psum_cell #(
      .M   (M),
      .POLY(POLY)
    ) u_cell (
      .pIn (pPrev),
      .sIn (sPrev),
      .aBit(aPrev[M-1-k]),
      .pOut(pNext)
    );

    if (k == LAST) begin : g_tail
      logic [M-1:0] resReg;
      logic         unusedTail;
      always_ff @(posedge clk) begin
        if (strb.loadEn[k]) resReg <= pNext ^ cPrev;
      end
      assign pPipe[k]   = resReg;
      assign unusedTail = ^aPrev;
    end else begin : g_carry
      logic [M-1:0] pReg;
      logic [M-1:0] aReg;
      logic [M-1:0] cReg;
      logic [M-1:0] sReg;
      always_ff @(posedge clk) begin
        if (strb.loadEn[k]) begin
          pReg <= pNext;
          aReg <= aPrev;
          cReg <= cPrev;
          sReg <= sPrev;
        end
      end
      assign pPipe[k] = pReg;
      assign aPipe[k] = aReg;
      assign cPipe[k] = cReg;
      assign sPipe[k] = sReg;
    end
  end

  assign resOut = pPipe[LAST];

endmodule

// File: rtl/gf_psum.sv
// Thin top: control and datapath of the A*B^2+C pipeline.
module gf_psum
  import gf_psum_pkg::*;
#(
  parameter int         M    = 4,
  parameter logic [M:0] POLY = 5'b10011
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         inVld,
  input  logic [M-1:0] aIn,
  input  logic [M-1:0] bIn,
  input  logic [M-1:0] cIn,
  output logic         outVld,
  output logic [M-1:0] resOut
);

  psum_strobe_t strb;

  gf_psum_ctrl #(
    .M(M)
  ) u_ctrl (
    .clk   (clk),
    .rstN  (rstN),
    .inVld (inVld),
    .strb  (strb),
    .outVld(outVld)
  );

  gf_psum_datapath #(
    .M   (M),
    .POLY(POLY)
  ) u_dp (
    .clk   (clk),
    .strb  (strb),
    .aIn   (aIn),
    .bIn   (bIn),
    .cIn   (cIn),
    .resOut(resOut)
  );

endmodule

// File: rtl/gf_psum_chk.sv
// Checker with its own shadow model: LSB-first shift-and-add multiply.
module gf_psum_chk #(
  parameter int         M    = 4,
  parameter logic [M:0] POLY = 5'b10011
) (
  input logic         clk,
  input logic         rstN,
  input logic         inVld,
  input logic [M-1:0] aIn,
  input logic [M-1:0] bIn,
  input logic [M-1:0] cIn,
  input logic         outVld,
  input logic [M-1:0] resOut
);

  function automatic logic [M-1:0] refMul(input logic [M-1:0] x, input logic [M-1:0] y);
    logic [M-1:0] acc;
    logic [M-1:0] t;
    acc = '0;
    t   = x;
    for (int i = 0; i < M; i++) begin
      if (y[i]) acc = acc ^ t;
      t = {t[M-2:0], 1'b0} ^ (t[M-1] ? POLY[M-1:0] : '0);
    end
    return acc;
  endfunction

  logic         shVld [M];
  logic [M-1:0] shExp [M];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int k = 0; k < M; k++) shVld[k] <= 1'b0;
    end else begin
      shVld[0] <= inVld;
      for (int k = 1; k < M; k++) shVld[k] <= shVld[k-1];
    end
  end

  always_ff @(posedge clk) begin
    shExp[0] <= refMul(aIn, refMul(bIn, bIn)) ^ cIn;
    for (int k = 1; k < M; k++) shExp[k] <= shExp[k-1];
  end

  initial begin
    poly_shape_chk : assert (M >= 2 && M <= 16 && POLY[M] && POLY[0]);
  end

  // R4
  rst_clear_chk : assert property (@(posedge clk) !rstN |-> !outVld);

  // R3
  vld_latency_chk : assert property (@(posedge clk) disable iff (!rstN)
    outVld == shVld[M-1]);

  // R1
  result_chk : assert property (@(posedge clk) disable iff (!rstN)
    outVld |-> resOut == shExp[M-1]);

  // R2
  in_known_chk : assert property (@(posedge clk) disable iff (!rstN)
    !$isunknown(inVld));

  // R2
  operand_known_chk : assert property (@(posedge clk) disable iff (!rstN)
    inVld |-> !$isunknown({aIn, bIn, cIn}));

endmodule

bind gf_psum gf_psum_chk #(.M(M), .POLY(POLY)) u_chk (.*);

// File: tb/test_gf_psum.sv
`timescale 1ns/1ps
module test_gf_psum;

  localparam int         M      = 4;
  localparam logic [M:0] POLY   = 5'b10011;
  localparam real        CLK_NS = 4.0;
  localparam int         NVEC   = 11;

  // {a, b, c, expected} as nibbles, field x^4+x+1
  localparam logic [15:0] VEC [NVEC] = '{
    16'h1204, 16'h1403, 16'h180C, 16'h1F0A, 16'h0799, 16'h5066,
    16'h2406, 16'h281A, 16'h880A, 16'hFFF3, 16'h330F
  };
  localparam string VTAG [NVEC] = '{
    "R5", "R7", "R5", "R5", "R6", "R6", "R1", "R1", "R1", "R1", "R1"
  };

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         inVld = 1'b0;
  logic [M-1:0] aIn = '0;
  logic [M-1:0] bIn = '0;
  logic [M-1:0] cIn = '0;
  logic         outVld;
  logic [M-1:0] resOut;

  int checks = 0;
  int errors = 0;

  always #(CLK_NS / 2.0) clk = ~clk;

  gf_psum #(.M(M), .POLY(POLY)) i_gf_psum (
    .clk   (clk),
    .rstN  (rstN),
    .inVld (inVld),
    .aIn   (aIn),
    .bIn   (bIn),
    .cIn   (cIn),
    .outVld(outVld),
    .resOut(resOut)
  );

  // Bench model: carry-less product, then reduce from the top bit down.
  function automatic logic [M-1:0] fieldMul(input logic [M-1:0] x, input logic [M-1:0] y);
    logic [2*M-2:0] prod;
    prod = '0;
    for (int i = 0; i < M; i++) if (y[i]) prod = prod ^ ((2*M-1)'(x) << i);
    for (int i = 2*M-2; i >= M; i--) if (prod[i]) prod = prod ^ ((2*M-1)'(POLY) << (i - M));
    return prod[M-1:0];
  endfunction

  function automatic logic [M-1:0] model(input logic [M-1:0] a, b, c);
    return fieldMul(a, fieldMul(b, b)) ^ c;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic bit isValidStep(input int k, input int bubbleMod);
    return (bubbleMod == 0) || ((k % bubbleMod) != 3);
  endfunction

  // Operands taken from the step index; optional bubbles every bubbleMod steps.
  task automatic runStream(input int steps, input int bubbleMod);
    for (int k = 0; k < steps + M; k++) begin
      @(negedge clk);
      if (k >= M) begin
        int s = k - M;
        logic [11:0] op = 12'(s);
        bit ev = isValidStep(s, bubbleMod);
        check("R3", outVld, ev);
        if (ev) check("R1", resOut, model(op[11:8], op[7:4], op[3:0]));
      end
      if (k < steps) begin
        logic [11:0] op = 12'(k);
        inVld = isValidStep(k, bubbleMod);
        aIn = inVld ? op[11:8] : '0;
        bIn = inVld ? op[7:4]  : '0;
        cIn = inVld ? op[3:0]  : '0;
      end else begin
        inVld = 1'b0; aIn = '0; bIn = '0; cIn = '0;
      end
    end
  endtask

  initial begin
    #(CLK_NS * 150000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    // Reset state (R4)
    repeat (3) @(negedge clk);
    check("R4", outVld, 1'b0);
    rstN = 1'b1;
    repeat (M + 1) begin
      @(negedge clk);
      check("R4", outVld, 1'b0);
    end

    // Table, back-to-back (R2 throughput)
    for (int k = 0; k < NVEC + M; k++) begin
      @(negedge clk);
      if (k >= M) begin
        check("R2", outVld, 1'b1);
        check(VTAG[k-M], resOut, VEC[k-M][3:0]);
      end
      if (k < NVEC) begin
        inVld = 1'b1;
        aIn = VEC[k][15:12]; bIn = VEC[k][11:8]; cIn = VEC[k][7:4];
      end else begin
        inVld = 1'b0; aIn = '0; bIn = '0; cIn = '0;
      end
    end

    // Exact latency of a lone operand set (R3)
    repeat (2) @(negedge clk);
    inVld = 1'b1; aIn = 4'h1; bIn = 4'h4; cIn = 4'h0;
    @(negedge clk);
    inVld = 1'b0; aIn = '0; bIn = '0;
    for (int j = 1; j <= M; j++) begin
      check("R3", outVld, (j == M - 1) ? 1'b0 : (j == M ? 1'b1 : 1'b0));
      if (j == M) check("R7", resOut, 4'h3);
      if (j < M) @(negedge clk);
    end

    // Exhaustive, no bubbles, then a bubbly stream (R1, R2, R3)
    runStream(4096, 0);
    runStream(300, 5);

    // Reset in mid-stream clears valids, nothing stale after release (R4)
    for (int k = 0; k < M - 1; k++) begin
      @(negedge clk);
      inVld = 1'b1; aIn = 4'h3; bIn = 4'h5; cIn = 4'h1;
    end
    @(negedge clk);
    inVld = 1'b0;
    rstN = 1'b0;
    #1;
    check("R4", outVld, 1'b0);
    @(negedge clk);
    rstN = 1'b1;
    repeat (M + 1) begin
      @(negedge clk);
      check("R4", outVld, 1'b0);
    end

    // Zero multiplier with all-ones addend (R6)
    inVld = 1'b1; aIn = 4'h0; bIn = 4'hF; cIn = 4'hF;
    @(negedge clk);
    inVld = 1'b0;
    repeat (M - 1) @(negedge clk);
    check("R6", outVld, 1'b1);
    check("R6", resOut, 4'hF);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule